// File: doc/BRIEF.md
# Dual-Loop Synthesizer Digital Core

This block is the digital heart of a two-loop frequency synthesizer. A single 13 MHz reference clock drives all of its logic. Two fixed reference dividers make one comparison strobe per loop: every 65 clocks (200 kHz) for the RF loop and every 13 clocks (1 MHz) for the IF loop. For each loop, a programmable feedback divider counts pulses from that loop's oscillator. In simulation these pulses arrive as clock-enable strobes sampled on the reference clock. A phase/frequency detector then compares the divided oscillator against the reference strobe. It drives up (source) and down (sink) commands to an external charge pump.

Divider ratios arrive as parallel words through a configuration port. Each word lands in a shadow register. A divider copies its shadow into its active ratio only when it reaches terminal count, so it never works from a half-changed ratio. The band-select bit travels with the RF ratio. In the second band (DCS) the RF divider puts a divide-by-two ahead of its counter. A power control holds both loops in reset while the synthesizer is off. Each loop reports lock after a run of narrow comparison pulses.

Top module: `dual_synth_core`

## Requirements
- R1: While powered, the RF loop's up output first rises at the 65th clock edge after `synth_on` rises, and the RF reference strobe then repeats every 65 clocks.
- R2: While powered, the IF loop's up output first rises at the 13th clock edge after `synth_on` rises, and the IF reference strobe then repeats every 13 clocks.
- R3: The RF feedback divider divides the count of `rf_vco_en` pulses by its 14-bit ratio N. With band GSM, `rf_dn` first rises on the clock edge that takes in the N-th pulse.
- R4: The IF feedback divider uses only bits 9:0 of a configuration word, and `if_dn` first rises on the edge that takes in the N-th `if_vco_en` pulse.
- R5: When band bit 1 (DCS) is active, the RF divider divides by 2·N.
- R6: A new ratio or band written while a loop runs takes effect only after that divider's current cycle has completed with its old ratio.
- R7: A reference strobe sets up and a feedback strobe sets down. When both are high they stay high together for exactly 2 clocks and are then cleared at the same edge.
- R8: While `synth_on` is low, up, down and lock stay low on both loops, oscillator pulses have no effect, and configuration writes are still accepted.
- R9: A loop's lock output rises at the reference strobe that closes the 16th consecutive comparison cycle in which up XOR down was high for at most 3 clocks. With matched ratios this falls at clock edge 16×65 for RF and 16×13 for IF.
- R10: A comparison cycle in which up XOR down was high for more than 3 clocks clears that loop's lock at its closing strobe.
- R11: `cfg_ready` is low during reset and high otherwise. A word is taken when `cfg_valid` and `cfg_ready` are both high. `cfg_sel`=0 writes the RF ratio (`cfg_word`) together with the band (`cfg_band`, 0 = GSM, 1 = DCS). `cfg_sel`=1 writes the IF ratio from `cfg_word[9:0]`. After reset the RF ratio is 65, the IF ratio is 13 and the band is GSM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 13 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| synth_on | input | 1 | Synthesizer power; low holds both loops in reset |
| rf_vco_en | input | 1 | RF oscillator pulse (clock enable) |
| if_vco_en | input | 1 | IF oscillator pulse (clock enable) |
| cfg_valid | input | 1 | Configuration word valid |
| cfg_ready | output | 1 | Configuration port ready |
| cfg_sel | input | 1 | Target: 0 RF ratio and band, 1 IF ratio |
| cfg_word | input | 14 | Ratio word |
| cfg_band | input | 1 | Band for RF write: 0 GSM, 1 DCS |
| rf_up | output | 1 | RF charge-pump source command |
| rf_dn | output | 1 | RF charge-pump sink command |
| if_up | output | 1 | IF charge-pump source command |
| if_dn | output | 1 | IF charge-pump sink command |
| rf_lock | output | 1 | RF loop lock flag |
| if_lock | output | 1 | IF loop lock flag |

## Verification
The loops are driven with three oscillator pulse patterns: no pulses, a pulse on every clock, and a pulse on every other clock. No pulses isolates the reference rates. Continuous pulses time the divider ratio directly. Alternating pulses show that the divider counts strobes rather than clocks. Matched ratios make both strobes coincide, which exposes the two-cycle overlap clear and drives lock. Mismatched ratios, a band change and a mid-cycle rewrite separate prescaling, deferred ratio loading and loss of lock from one another.

// File: rtl/dsyn_pkg.sv
package dsyn_pkg;
  typedef enum logic {BAND_GSM = 1'b0, BAND_DCS = 1'b1} band_e;
  typedef enum logic {SEL_RF = 1'b0, SEL_IF = 1'b1} cfg_sel_e;
endpackage

// File: rtl/dsyn_ref_div.sv
module dsyn_ref_div #(
  parameter int DIV = 65
) (
  input  logic clk,
  input  logic hold,
  output logic tick
);
  localparam int CW = $clog2(DIV);
  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (hold)      cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dsyn_fb_div.sv
module dsyn_fb_div #(
  parameter int W           = 14,
  parameter bit PRESCALE_EN = 1'b1
) (
  input  logic         clk,
  input  logic         hold,
  input  logic         vco_en,
  input  logic [W-1:0] ratio_shadow,
  input  logic         band_shadow,
  output logic         tick
);
  logic [W-1:0] active;
  logic [W-1:0] cnt;
  logic [W-1:0] term;
  logic         band_act;
  logic         pre;
  logic         adv;

  // ratio 0 behaves as ratio 1
  assign term = (active == '0) ? '0 : active - 1'b1;
  assign adv  = vco_en && (!band_act || pre);
  assign tick = adv && (cnt == term);

  always_ff @(posedge clk) begin
    if (hold) begin
      active   <= ratio_shadow;
      band_act <= band_shadow && PRESCALE_EN;
      cnt      <= '0;
      pre      <= 1'b0;
    end else if (tick) begin
      // cycle complete: only point where the shadow is taken in
      active   <= ratio_shadow;
      band_act <= band_shadow && PRESCALE_EN;
      cnt      <= '0;
      pre      <= 1'b0;
    end else begin
      if (vco_en && band_act) pre <= ~pre;
      if (adv) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dsyn_pfd.sv
module dsyn_pfd #(
  parameter int RST_DLY = 2
) (
  input  logic clk,
  input  logic hold,
  input  logic ref_tick,
  input  logic fb_tick,
  output logic up,
  output logic dn
);
  localparam int CW = $clog2(RST_DLY) + 1;
  logic [CW-1:0] both_cnt;
  logic          both;
  logic          clear;

  assign both  = up && dn;
  assign clear = both && (both_cnt == CW'(RST_DLY - 1));

  always_ff @(posedge clk) begin
    if (hold) begin
      up       <= 1'b0;
      dn       <= 1'b0;
      both_cnt <= '0;
    end else begin
      up       <= ref_tick || (up && !clear);
      dn       <= fb_tick  || (dn && !clear);
      both_cnt <= (both && !clear) ? both_cnt + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/dsyn_lock.sv
module dsyn_lock #(
  parameter bit LOCK_EN = 1'b1,
  parameter int THR     = 3,
  parameter int CYCLES  = 16
) (
  input  logic clk,
  input  logic hold,
  input  logic ref_tick,
  input  logic up,
  input  logic dn,
  output logic lock
);
  generate
    if (LOCK_EN) begin : g_lock
      localparam int WCW = $clog2(THR + 2);
      localparam int GCW = $clog2(CYCLES + 1);
      logic [WCW-1:0] width;
      logic [GCW-1:0] good;
      logic           narrow;

      assign narrow = (width <= WCW'(THR));
      assign lock   = (good == GCW'(CYCLES));

      always_ff @(posedge clk) begin
        if (hold) begin
          width <= '0;
          good  <= '0;
        end else if (ref_tick) begin
          width <= '0;
          if (!narrow)    good <= '0;
          else if (!lock) good <= good + 1'b1;
        end else if ((up ^ dn) && narrow) begin
          width <= width + 1'b1;
        end
      end
    end else begin : g_nolock
      assign lock = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dsyn_loop.sv
module dsyn_loop #(
  parameter int W           = 14,
  parameter int REF_DIV     = 65,
  parameter bit PRESCALE_EN = 1'b1,
  parameter int RST_DLY     = 2,
  parameter bit LOCK_EN     = 1'b1,
  parameter int LOCK_THR    = 3,
  parameter int LOCK_CYCLES = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         on,
  input  logic         vco_en,
  input  logic [W-1:0] ratio_shadow,
  input  logic         band_shadow,
  output logic         up,
  output logic         dn,
  output logic         lock
);
  logic hold;
  logic ref_tick;
  logic fb_tick;

  assign hold = !rst_n || !on;

  dsyn_ref_div #(.DIV(REF_DIV)) u_ref (
    .clk(clk), .hold(hold), .tick(ref_tick)
  );

  dsyn_fb_div #(.W(W), .PRESCALE_EN(PRESCALE_EN)) u_fb (
    .clk(clk), .hold(hold), .vco_en(vco_en),
    .ratio_shadow(ratio_shadow), .band_shadow(band_shadow), .tick(fb_tick)
  );

  dsyn_pfd #(.RST_DLY(RST_DLY)) u_pfd (
    .clk(clk), .hold(hold), .ref_tick(ref_tick), .fb_tick(fb_tick),
    .up(up), .dn(dn)
  );

  dsyn_lock #(.LOCK_EN(LOCK_EN), .THR(LOCK_THR), .CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .hold(hold), .ref_tick(ref_tick), .up(up), .dn(dn), .lock(lock)
  );
endmodule

// File: rtl/dual_synth_core.sv
module dual_synth_core #(
  parameter int RF_W           = 14,
  parameter int IF_W           = 10,
  parameter int RF_REF_DIV     = 65,
  parameter int IF_REF_DIV     = 13,
  parameter int RF_RESET_RATIO = 65,
  parameter int IF_RESET_RATIO = 13,
  parameter int PFD_RST_DLY    = 2,
  parameter bit LOCK_EN        = 1'b1,
  parameter int LOCK_THR       = 3,
  parameter int LOCK_CYCLES    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            synth_on,
  input  logic            rf_vco_en,
  input  logic            if_vco_en,
  input  logic            cfg_valid,
  output logic            cfg_ready,
  input  logic            cfg_sel,
  input  logic [RF_W-1:0] cfg_word,
  input  logic            cfg_band,
  output logic            rf_up,
  output logic            rf_dn,
  output logic            if_up,
  output logic            if_dn,
  output logic            rf_lock,
  output logic            if_lock
);
  import dsyn_pkg::*;

  logic [RF_W-1:0] rf_shadow;
  logic [IF_W-1:0] if_shadow;
  band_e           band_shadow;
  logic            take;

  assign cfg_ready = rst_n;
  assign take      = cfg_valid && cfg_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_shadow   <= RF_W'(RF_RESET_RATIO);
      if_shadow   <= IF_W'(IF_RESET_RATIO);
      band_shadow <= BAND_GSM;
    end else if (take) begin
      if (cfg_sel_e'(cfg_sel) == SEL_RF) begin
        rf_shadow   <= cfg_word;
        band_shadow <= band_e'(cfg_band);
      end else begin
        if_shadow   <= cfg_word[IF_W-1:0];
      end
    end
  end

  dsyn_loop #(
    .W(RF_W), .REF_DIV(RF_REF_DIV), .PRESCALE_EN(1'b1), .RST_DLY(PFD_RST_DLY),
    .LOCK_EN(LOCK_EN), .LOCK_THR(LOCK_THR), .LOCK_CYCLES(LOCK_CYCLES)
  ) u_rf (
    .clk(clk), .rst_n(rst_n), .on(synth_on), .vco_en(rf_vco_en),
    .ratio_shadow(rf_shadow), .band_shadow(band_shadow == BAND_DCS),
    .up(rf_up), .dn(rf_dn), .lock(rf_lock)
  );

  dsyn_loop #(
    .W(IF_W), .REF_DIV(IF_REF_DIV), .PRESCALE_EN(1'b0), .RST_DLY(PFD_RST_DLY),
    .LOCK_EN(LOCK_EN), .LOCK_THR(LOCK_THR), .LOCK_CYCLES(LOCK_CYCLES)
  ) u_if (
    .clk(clk), .rst_n(rst_n), .on(synth_on), .vco_en(if_vco_en),
    .ratio_shadow(if_shadow), .band_shadow(1'b0),
    .up(if_up), .dn(if_dn), .lock(if_lock)
  );
endmodule

// File: rtl/dsyn_chk.sv
module dsyn_chk #(
  parameter int RST_DLY = 2
) (
  input logic clk,
  input logic rst_n,
  input logic synth_on,
  input logic rf_up,
  input logic rf_dn,
  input logic if_up,
  input logic if_dn,
  input logic rf_lock,
  input logic if_lock
);
  int rf_both_run;
  int if_both_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_both_run <= 0;
      if_both_run <= 0;
    end else begin
      rf_both_run <= (rf_up && rf_dn) ? rf_both_run + 1 : 0;
      if_both_run <= (if_up && if_dn) ? if_both_run + 1 : 0;
    end
  end

  assert_rf_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_both_run <= RST_DLY);
  assert_if_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    if_both_run <= RST_DLY);
  assert_rf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !synth_on |=> (!rf_up && !rf_dn && !rf_lock));
  assert_if_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !synth_on |=> (!if_up && !if_dn && !if_lock));
  assert_rf_lock_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rf_lock) |-> $past(synth_on));
  assert_if_lock_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(if_lock) |-> $past(synth_on));
endmodule

bind dual_synth_core dsyn_chk #(.RST_DLY(PFD_RST_DLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .synth_on(synth_on),
  .rf_up(rf_up), .rf_dn(rf_dn), .if_up(if_up), .if_dn(if_dn),
  .rf_lock(rf_lock), .if_lock(if_lock)
);

// File: tb/sim_dual_synth_core.sv
module sim_dual_synth_core;
  localparam time CLK_PERIOD = 76ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        synth_on = 1'b0;
  logic        rf_vco_en = 1'b0;
  logic        if_vco_en = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic        cfg_sel = 1'b0;
  logic [13:0] cfg_word = '0;
  logic        cfg_band = 1'b0;
  logic        rf_up, rf_dn, if_up, if_dn, rf_lock, if_lock;

  int n_checks = 0;
  int n_fail   = 0;

  // recorded edge numbers (-1 = never)
  int rf_up_rise, if_up_rise, if_dn_rise;
  int rf_dn_rise1, rf_dn_rise2;
  int rf_lock_rise, rf_lock_fall, if_lock_rise, if_lock_fall;
  logic both_rec [0:1300];

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_synth_core u0 (
    .clk(clk), .rst_n(rst_n), .synth_on(synth_on),
    .rf_vco_en(rf_vco_en), .if_vco_en(if_vco_en),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_sel(cfg_sel),
    .cfg_word(cfg_word), .cfg_band(cfg_band),
    .rf_up(rf_up), .rf_dn(rf_dn), .if_up(if_up), .if_dn(if_dn),
    .rf_lock(rf_lock), .if_lock(if_lock)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic sel, input logic [13:0] word, input logic band);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_sel = sel; cfg_word = word; cfg_band = band;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  function automatic logic pat_val(input int pat, input int e);
    if (pat == 1) return 1'b1;
    if (pat == 2) return (e % 2 == 0);
    return 1'b0;
  endfunction

  // pattern: 0 none, 1 every clock, 2 every other clock (first clock high)
  task automatic run_loop(input int n, input int pat_rf, input int pat_if,
                          input int wr_e, input logic wr_sel,
                          input logic [13:0] wr_word, input logic wr_band);
    logic p_rf_up, p_rf_dn, p_if_up, p_if_dn, p_rl, p_il;
    rf_up_rise = -1; if_up_rise = -1; if_dn_rise = -1;
    rf_dn_rise1 = -1; rf_dn_rise2 = -1;
    rf_lock_rise = -1; rf_lock_fall = -1; if_lock_rise = -1; if_lock_fall = -1;
    for (int i = 0; i <= 1300; i++) both_rec[i] = 1'b0;
    p_rf_up = 0; p_rf_dn = 0; p_if_up = 0; p_if_dn = 0; p_rl = 0; p_il = 0;
    @(negedge clk);
    synth_on  = 1'b1;
    rf_vco_en = pat_val(pat_rf, 0);
    if_vco_en = pat_val(pat_if, 0);
    for (int e = 1; e <= n; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (e <= 1300) both_rec[e] = rf_up && rf_dn;
      if (rf_up && !p_rf_up && rf_up_rise < 0) rf_up_rise = e;
      if (if_up && !p_if_up && if_up_rise < 0) if_up_rise = e;
      if (if_dn && !p_if_dn && if_dn_rise < 0) if_dn_rise = e;
      if (rf_dn && !p_rf_dn) begin
        if (rf_dn_rise1 < 0) rf_dn_rise1 = e;
        else if (rf_dn_rise2 < 0) rf_dn_rise2 = e;
      end
      if (rf_lock && !p_rl && rf_lock_rise < 0) rf_lock_rise = e;
      if (!rf_lock && p_rl && rf_lock_fall < 0) rf_lock_fall = e;
      if (if_lock && !p_il && if_lock_rise < 0) if_lock_rise = e;
      if (!if_lock && p_il && if_lock_fall < 0) if_lock_fall = e;
      p_rf_up = rf_up; p_rf_dn = rf_dn; p_if_up = if_up; p_if_dn = if_dn;
      p_rl = rf_lock; p_il = if_lock;
      rf_vco_en = pat_val(pat_rf, e);
      if_vco_en = pat_val(pat_if, e);
      if (e == wr_e) begin
        cfg_valid = 1'b1; cfg_sel = wr_sel; cfg_word = wr_word; cfg_band = wr_band;
      end else begin
        cfg_valid = 1'b0;
      end
    end
    synth_on = 1'b0; cfg_valid = 1'b0; rf_vco_en = 1'b0; if_vco_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R11 ready low in reset", int'(cfg_ready), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R11 ready after reset", int'(cfg_ready), 1);
    check("R8 outputs idle after reset", int'({rf_up, rf_dn, if_up, if_dn, rf_lock, if_lock}), 0);
  endtask

  task automatic t_ref_rates;
    run_loop(100, 0, 0, -1, 1'b0, '0, 1'b0);
    check("R1 RF up first rise", rf_up_rise, 65);
    check("R2 IF up first rise", if_up_rise, 13);
    check("R3 RF dn without pulses", rf_dn_rise1, -1);
  endtask

  task automatic t_rf_div;
    write_cfg(1'b0, 14'd60, 1'b0);
    run_loop(80, 1, 0, -1, 1'b0, '0, 1'b0);
    check("R3 RF dn ratio 60 continuous", rf_dn_rise1, 60);
    write_cfg(1'b0, 14'd10, 1'b0);
    run_loop(40, 2, 0, -1, 1'b0, '0, 1'b0);
    check("R3 RF dn ratio 10 alternating", rf_dn_rise1, 19);
  endtask

  task automatic t_if_div;
    write_cfg(1'b1, 14'h040A, 1'b0);  // bit 10 set, must be dropped
    run_loop(20, 0, 1, -1, 1'b0, '0, 1'b0);
    check("R4 IF dn ratio 10 from low bits", if_dn_rise, 10);
    write_cfg(1'b1, 14'd13, 1'b0);
  endtask

  task automatic t_band;
    write_cfg(1'b0, 14'd30, 1'b1);
    run_loop(80, 1, 0, -1, 1'b0, '0, 1'b0);
    check("R5 DCS ratio 30 doubles", rf_dn_rise1, 60);
    write_cfg(1'b0, 14'd30, 1'b0);
    run_loop(40, 1, 0, -1, 1'b0, '0, 1'b0);
    check("R5 GSM ratio 30", rf_dn_rise1, 30);
  endtask

  task automatic t_overlap;
    write_cfg(1'b0, 14'd65, 1'b0);
    run_loop(70, 1, 0, -1, 1'b0, '0, 1'b0);
    check("R7 dn with matched ratio", rf_dn_rise1, 65);
    check("R7 overlap before", int'(both_rec[64]), 0);
    check("R7 overlap clock 1", int'(both_rec[65]), 1);
    check("R7 overlap clock 2", int'(both_rec[66]), 1);
    check("R7 cleared together", int'(both_rec[67]), 0);
  endtask

  task automatic t_safe_update;
    write_cfg(1'b0, 14'd60, 1'b0);
    run_loop(140, 1, 0, 30, 1'b0, 14'd70, 1'b0);
    check("R6 old ratio kept for running cycle", rf_dn_rise1, 60);
    check("R6 new ratio after terminal count", rf_dn_rise2, 130);
  endtask

  task automatic t_off;
    int bad = 0;
    write_cfg(1'b0, 14'd5, 1'b0);
    @(negedge clk);
    rf_vco_en = 1'b1; if_vco_en = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (rf_up || rf_dn || if_up || if_dn || rf_lock || if_lock) bad++;
    end
    rf_vco_en = 1'b0; if_vco_en = 1'b0;
    check("R8 outputs held while off", bad, 0);
    run_loop(10, 1, 0, -1, 1'b0, '0, 1'b0);
    check("R8 write while off accepted", rf_dn_rise1, 5);
  endtask

  task automatic t_lock;
    write_cfg(1'b0, 14'd65, 1'b0);
    write_cfg(1'b1, 14'd13, 1'b0);
    run_loop(1250, 1, 1, 1060, 1'b0, 14'd60, 1'b0);
    check("R9 RF lock after 16 cycles", rf_lock_rise, 1040);
    check("R9 IF lock after 16 cycles", if_lock_rise, 208);
    check("R10 RF lock lost after mismatch", int'(rf_lock_fall > 1060 && rf_lock_fall <= 1200), 1);
    check("R10 IF lock kept", if_lock_fall, -1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_ref_rates();
    t_rf_div();
    t_if_div();
    t_band();
    t_overlap();
    t_safe_update();
    t_off();
    t_lock();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule